// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block runs one external memory port on behalf of a processor core. The core presents a request (address, memory space, direction, write data and an indivisible read-modify-write flag) and holds it until a one-clock done pulse. The sequencer then steps the port through the phases of a bus cycle. Each rising clock edge advances one phase. It drives the address, the two space-select lines, read/write, the bus strobe, the transfer strobe and the bus lock, and it hands the read data back to the core.

A basic cycle takes four phases, T0 to T3. Wait states lengthen it. Each wait state is a T2/TW phase pair. The number of wait states is the larger of two values: a minimum count loaded at the start of the cycle, and the number of T2 phases in which the active-low acknowledge input, sampled on the falling clock edge, was still deasserted. For an indivisible update, the lock output covers the read cycle, the gap and the write cycle. A hold input forces the lock on at any time.

Top module: `xbus_seq`

## Requirements
- R1: While reset is asserted, bs_no, ts_no and bl_no (with lock_hold_i low) are 1, ss_o is 2'b11, rw_o is 1, data_oe_o and done_o are 0, and addr_o is 0.
- R2: A request presented in an idle phase is accepted at the next rising edge. That phase is T0: bs_no falls and addr_o and rw_o (1 for a read, 0 for a write) show the request. These values stay stable until the cycle ends, even if the request inputs change.
- R3: During a cycle, ss_o carries the space code: space_i 0 (program) gives 2'b10, 1 (X data) gives 2'b01, and 2 or 3 (Y data) gives 2'b00. ss_o is never 2'b11 while bs_no is low.
- R4: ts_no goes low in the phase after T0 (the second phase), and only while bs_no is low. With no wait states, ts_no is low for two phases and done_o is high in the fourth phase.
- R5: With acknowledge asserted throughout, a minimum wait count W inserts exactly W wait states. The cycle then spans 4+2W phases, and bs_no is low for 3+2W of them.
- R6: If acknowledge is held deasserted through the first K T2 phases, the cycle carries max(W, K) wait states.
- R7: For a read, rdata_o in the done phase equals data_i as driven during the final T2 phase, which is the phase whose end raises ts_no.
- R8: For a write, data_oe_o is high from the first T2 phase through T3, with data_o equal to the write data. data_oe_o is low at all other times.
- R9: In an idle phase, ss_o is 2'b11, rw_o is 1, bs_no and ts_no are 1, data_oe_o is 0, and addr_o keeps the address of the last cycle. Acknowledge has no effect while the bus is idle.
- R10: done_o is a single-phase pulse in T3. A request held high through the done phase starts no cycle before the following idle phase.
- R11: When rmw_i is set on a read request, bl_no falls in that read's T0. It stays low through the idle phase between the read and the write, and it rises in the first idle phase after a write request that also has rmw_i set.
- R12: While lock_hold_i is 1, bl_no is 0, whatever the bus is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock, one phase per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core access request, held until done |
| we_i | input | 1 | 1 = write, 0 = read |
| rmw_i | input | 1 | Request is one half of an indivisible read-modify-write |
| space_i | input | 2 | 0 program, 1 X data, 2/3 Y data |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Request write data |
| wait_min_i | input | WAIT_W | Minimum wait states, loaded at accept |
| lock_hold_i | input | 1 | Forces bus lock asserted |
| rdata_o | output | DATA_W | Read data returned to core |
| done_o | output | 1 | One-phase completion pulse |
| addr_o | output | ADDR_W | External address |
| ss_o | output | 2 | Space select lines, 2'b11 when idle |
| rw_o | output | 1 | High read, low write, high when idle |
| bs_no | output | 1 | Bus strobe, active low |
| ts_no | output | 1 | Transfer strobe, active low |
| bl_no | output | 1 | Bus lock, active low |
| ack_ni | input | 1 | Transfer acknowledge, active low, sampled on falling edge |
| data_i | input | DATA_W | External read data |
| data_o | output | DATA_W | External write data |
| data_oe_o | output | 1 | Write data drive enable |

## Verification
The cycle length is exercised with a zero minimum and prompt acknowledge, with a minimum alone, with a late acknowledge alone, and with both set so that either one is the larger. These cases tell a maximum apart from a sum or from either source alone. Read data is driven with random values in every phase except the final T2, so a capture taken on the wrong edge shows up. Address inputs are scrambled in T3, and a new request is held through the done phase, to show the captured values and the one-phase gap between cycles. Read-modify-write pairs and the lock-hold input are mixed into otherwise random traffic, and acknowledge is toggled during idle phases to show that it is ignored there.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T0   = 3'd1,
    PH_T1   = 3'd2,
    PH_T2   = 3'd3,
    PH_TW   = 3'd4,
    PH_T3   = 3'd5
  } phase_e;

  localparam logic [1:0] SS_NONE = 2'b11;
  localparam logic [1:0] SS_PROG = 2'b10;
  localparam logic [1:0] SS_XMEM = 2'b01;
  localparam logic [1:0] SS_YMEM = 2'b00;

  function automatic logic [1:0] space_code(input logic [1:0] sp);
    case (sp)
      2'd0:    space_code = SS_PROG;
      2'd1:    space_code = SS_XMEM;
      default: space_code = SS_YMEM;
    endcase
  endfunction

endpackage

// File: rtl/xbus_phase_fsm.sv
module xbus_phase_fsm
  import xbus_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] wait_min_i,
  input  logic              ack_ni,
  output phase_e            phase_o,
  output logic              fin_o
);

  phase_e            phase_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic              ack_seen_q;

  // acknowledge is sampled on the falling edge, mid-phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_seen_q <= 1'b0;
    else         ack_seen_q <= ~ack_ni;
  end

  assign fin_o = (phase_q == PH_T2) && (wcnt_q == '0) && ack_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      wcnt_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_T0;
          wcnt_q  <= wait_min_i;
        end
        PH_T0:   phase_q <= PH_T1;
        PH_T1:   phase_q <= PH_T2;
        PH_T2:   phase_q <= fin_o ? PH_T3 : PH_TW;
        PH_TW: begin
          phase_q <= PH_T2;
          if (wcnt_q != '0) wcnt_q <= wcnt_q - 1'b1;
        end
        PH_T3:   phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/xbus_lock.sv
module xbus_lock
  import xbus_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   accept_i,
  input  logic   rmw_i,
  input  phase_e phase_i,
  input  logic   cur_we_i,
  input  logic   cur_rmw_i,
  input  logic   hold_i,
  output logic   bl_no
);

  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
    end else if (accept_i && rmw_i) begin
      lock_q <= 1'b1;
    end else if (phase_i == PH_T3 && cur_rmw_i && cur_we_i) begin
      lock_q <= 1'b0;
    end
  end

  assign bl_no = ~(lock_q | hold_i);

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              fin_i,
  input  phase_e            phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        space_i,
  input  logic              we_i,
  input  logic              rmw_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        ss_o,
  output logic              rw_o,
  output logic              bs_no,
  output logic              ts_no,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              cur_we_o,
  output logic              cur_rmw_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        space_q;
  logic              we_q;
  logic              rmw_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      space_q <= '0;
      we_q    <= 1'b0;
      rmw_q   <= 1'b0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      space_q <= space_i;
      we_q    <= we_i;
      rmw_q   <= rmw_i;
      wdata_q <= wdata_i;
    end
  end

  // capture at the edge that raises the transfer strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (fin_i && !we_q)  rdata_q <= data_i;
  end

  assign busy      = (phase_i != PH_IDLE);
  assign addr_o    = addr_q;
  assign ss_o      = busy ? space_code(space_q) : SS_NONE;
  assign rw_o      = busy ? ~we_q : 1'b1;
  assign bs_no     = !(phase_i inside {PH_T0, PH_T1, PH_T2, PH_TW});
  assign ts_no     = !(phase_i inside {PH_T1, PH_T2, PH_TW});
  assign data_oe_o = we_q && (phase_i inside {PH_T2, PH_TW, PH_T3});
  assign data_o    = wdata_q;
  assign rdata_o   = rdata_q;
  assign done_o    = (phase_i == PH_T3);
  assign cur_we_o  = we_q;
  assign cur_rmw_o = rmw_q;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              rmw_i,
  input  logic [1:0]        space_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WAIT_W-1:0] wait_min_i,
  input  logic              lock_hold_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        ss_o,
  output logic              rw_o,
  output logic              bs_no,
  output logic              ts_no,
  output logic              bl_no,
  input  logic              ack_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);

  phase_e phase;
  logic   fin;
  logic   accept;
  logic   cur_we;
  logic   cur_rmw;

  assign accept = req_i && (phase == PH_IDLE);

  xbus_phase_fsm #(.WAIT_W(WAIT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .wait_min_i (wait_min_i),
    .ack_ni     (ack_ni),
    .phase_o    (phase),
    .fin_o      (fin)
  );

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .fin_i     (fin),
    .phase_i   (phase),
    .addr_i    (addr_i),
    .space_i   (space_i),
    .we_i      (we_i),
    .rmw_i     (rmw_i),
    .wdata_i   (wdata_i),
    .data_i    (data_i),
    .addr_o    (addr_o),
    .ss_o      (ss_o),
    .rw_o      (rw_o),
    .bs_no     (bs_no),
    .ts_no     (ts_no),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .rdata_o   (rdata_o),
    .done_o    (done_o),
    .cur_we_o  (cur_we),
    .cur_rmw_o (cur_rmw)
  );

  xbus_lock u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .rmw_i     (rmw_i),
    .phase_i   (phase),
    .cur_we_i  (cur_we),
    .cur_rmw_i (cur_rmw),
    .hold_i    (lock_hold_i),
    .bl_no     (bl_no)
  );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bs_no,
  input logic              ts_no,
  input logic              done_o,
  input logic              rw_o,
  input logic              data_oe_o,
  input logic [1:0]        ss_o,
  input logic [ADDR_W-1:0] addr_o
);

  // R4
  ts_within_bs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_no |-> !bs_no);

  // R4
  ts_after_bs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ts_no) |-> $past(!bs_no));

  // R9
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bs_no && !done_o) |-> (ss_o == 2'b11 && rw_o && !data_oe_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_after_ts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!ts_no));

  // R2
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bs_no && $past(!bs_no)) |-> $stable(addr_o));

  // R3
  space_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bs_no |-> (ss_o != 2'b11));

endmodule

bind xbus_seq xbus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bs_no     (bs_no),
  .ts_no     (ts_no),
  .done_o    (done_o),
  .rw_o      (rw_o),
  .data_oe_o (data_oe_o),
  .ss_o      (ss_o),
  .addr_o    (addr_o)
);

// File: tb/xbus_seq_bench.sv
module xbus_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, rmw = 1'b0, hold = 1'b0, ack_n = 1'b1;
  logic [1:0]    space = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, din = '0;
  logic [WW-1:0] wmin = '0;
  logic [DW-1:0] rdata, dout;
  logic [AW-1:0] addr_o;
  logic [1:0]    ss;
  logic          done, rw, bs_n, ts_n, bl_n, oe;

  int n_chk = 0;
  int n_fail = 0;
  logic lock_exp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_seq #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) u_xbus_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .rmw_i(rmw),
    .space_i(space), .addr_i(addr), .wdata_i(wdata), .wait_min_i(wmin),
    .lock_hold_i(hold), .rdata_o(rdata), .done_o(done), .addr_o(addr_o),
    .ss_o(ss), .rw_o(rw), .bs_no(bs_n), .ts_no(ts_n), .bl_no(bl_n),
    .ack_ni(ack_n), .data_i(din), .data_o(dout), .data_oe_o(oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_code(input logic [1:0] sp);
    if (sp == 2'd0)      return 2'b10;
    else if (sp == 2'd1) return 2'b01;
    else                 return 2'b00;
  endfunction

  // starts in an idle phase at posedge+1; ends in the next idle phase at posedge+1
  task automatic access(input logic [AW-1:0] a, input logic [1:0] sp, input bit w_en,
                        input logic [DW-1:0] wd, input bit is_rmw, input int w, input int k,
                        input bit keep_req);
    int m;
    int last;
    logic [DW-1:0] rexp;
    m = (w > k) ? w : k;
    last = 3 + 2*m;
    rexp = $urandom;
    req = 1'b1; addr = a; space = sp; we = w_en; wdata = wd; rmw = is_rmw;
    wmin = WW'(w); ack_n = 1'b1;
    for (int idx = 0; idx <= last; idx++) begin
      @(posedge clk); #1;
      if (idx == 0 && is_rmw) lock_exp = 1'b1;
      chk(bs_n == !(idx <= last-1), "R5 bs_no", bs_n, !(idx <= last-1));
      chk(ts_n == !(idx >= 1 && idx <= last-1), "R4/R6 ts_no", ts_n, !(idx >= 1 && idx <= last-1));
      chk(done == (idx == last), "R10 done_o", done, idx == last);
      chk(ss == exp_code(sp), "R3 ss_o", ss, exp_code(sp));
      chk(addr_o == a, "R2 addr_o", addr_o, a);
      chk(rw == !w_en, "R2 rw_o", rw, !w_en);
      chk(oe == (w_en && idx >= 2), "R8 data_oe_o", oe, w_en && idx >= 2);
      if (w_en && idx >= 2) chk(dout == wd, "R8 data_o", dout, wd);
      chk(bl_n == !(lock_exp | hold), "R11 bl_no", bl_n, !(lock_exp | hold));
      if (idx == last && !w_en) chk(rdata == rexp, "R7 rdata_o", rdata, rexp);
      ack_n = (idx < 2 + 2*k);
      din = (idx == last-1) ? rexp : DW'($urandom);
      if (idx == last) begin
        req = keep_req;
        addr = $urandom; space = 2'($urandom); we = 1'($urandom);
        wmin = WW'($urandom);
      end
    end
    @(posedge clk); #1;
    if (is_rmw && w_en) lock_exp = 1'b0;
    chk(bs_n && ts_n, "R9/R10 idle strobes", {bs_n, ts_n}, 2'b11);
    chk(ss == 2'b11, "R9 idle ss_o", ss, 2'b11);
    chk(rw == 1'b1, "R9 idle rw_o", rw, 1);
    chk(oe == 1'b0 && done == 1'b0, "R9 idle oe/done", {oe, done}, 0);
    chk(addr_o == a, "R9 addr hold", addr_o, a);
    chk(bl_n == !(lock_exp | hold), "R11 bl_no idle", bl_n, !(lock_exp | hold));
    req = 1'b0;
    ack_n = 1'($urandom);
  endtask

  task automatic idle_phases(input int n);
    for (int i = 0; i < n; i++) begin
      ack_n = 1'($urandom);
      @(posedge clk); #1;
      chk(bs_n && ts_n && ss == 2'b11, "R9 ack ignored idle", {bs_n, ts_n, ss}, 4'hf);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(bs_n && ts_n, "R1 strobes", {bs_n, ts_n}, 2'b11);
    chk(bl_n == 1'b1, "R1 bl_no", bl_n, 1);
    chk(ss == 2'b11, "R1 ss_o", ss, 2'b11);
    chk(rw == 1'b1, "R1 rw_o", rw, 1);
    chk(oe == 1'b0 && done == 1'b0, "R1 oe/done", {oe, done}, 0);
    chk(addr_o == '0, "R1 addr_o", addr_o, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // directed: zero wait, each space, mins, late acks, max of both
    access(32'h0000_1000, 2'd0, 1'b0, '0, 1'b0, 0, 0, 1'b0);            // R4
    access(32'h0000_2004, 2'd1, 1'b1, 32'hCAFE_0001, 1'b0, 0, 0, 1'b0); // R8
    access(32'h0000_3008, 2'd2, 1'b0, '0, 1'b0, 3, 0, 1'b0);            // R5
    access(32'h0000_400C, 2'd3, 1'b1, 32'h1234_5678, 1'b0, 0, 4, 1'b0); // R6
    access(32'h0000_5010, 2'd0, 1'b0, '0, 1'b0, 2, 5, 1'b0);            // R6
    access(32'h0000_6014, 2'd1, 1'b0, '0, 1'b0, 5, 2, 1'b0);            // R6
    idle_phases(4);                                                      // R9
    // R10: request held through done phase is not taken before idle
    access(32'h0000_7018, 2'd2, 1'b0, '0, 1'b0, 1, 0, 1'b1);
    access(32'h0000_801C, 2'd0, 1'b1, 32'hAAAA_5555, 1'b0, 0, 1, 1'b0);
    // R11: locked pair
    access(32'h0000_9000, 2'd1, 1'b0, '0, 1'b1, 1, 1, 1'b0);
    access(32'h0000_9000, 2'd1, 1'b1, 32'h0F0F_F0F0, 1'b1, 0, 2, 1'b0);
    // R12: hold forces lock
    hold = 1'b1;
    @(posedge clk); #1;
    chk(bl_n == 1'b0, "R12 hold idle", bl_n, 0);
    access(32'h0000_A000, 2'd2, 1'b0, '0, 1'b0, 0, 0, 1'b0);
    hold = 1'b0;
    @(posedge clk); #1;
    chk(bl_n == 1'b1, "R12 hold release", bl_n, 1);

    for (int n = 0; n < 80; n++) begin
      int w;
      int k;
      logic [AW-1:0] a;
      logic [1:0] sp;
      w = $urandom % 6;
      k = $urandom % 6;
      a = $urandom;
      sp = 2'($urandom);
      if ($urandom % 5 == 0) begin
        access(a, sp, 1'b0, '0, 1'b1, w, k, 1'b0);
        access(a, sp, 1'b1, DW'($urandom), 1'b1, k, w, 1'b0);
      end else begin
        access(a, sp, 1'($urandom), DW'($urandom), 1'b0, w, k, 1'($urandom));
      end
      if ($urandom % 3 == 0) idle_phases(1 + $urandom % 3);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule